// File: doc/BRIEF.md
# Bit-Serial Circuit-Switched Router Stage

This block is one switching stage for a lockstep array of processing elements (PEs). Groups of PEs share a router port. A concentrator takes one PE of each group, chosen by a broadcast PE index, and puts it on that port's serial lines. A full crossbar can then join any port's outgoing line to any other port's incoming line. Every path is one bit wide, and a word crosses it over several cycles.

Operation runs in two phases, and all ports step through them together. In the setup phase, each port shifts in a request bit, then a destination port number, then a parity bit. An arbiter grants each free destination to the lowest-numbered port that asks for it. Every other valid request is refused. In the data phase, each circuit carries a forward word from source to destination. In the same cycles it carries a reply word from destination back to source. Both directions have the same one-cycle latency on every path. Parity errors on the address and on the data set sticky flags per port. A broadcast release strobe removes every circuit at once.

Top module: `serial_router`

## Requirements
- R1: Port p listens to PE p*PES_PER_PORT+peSel. The port's received forward and reply bits go only to PE p*PES_PER_PORT+selQ, where selQ is peSel delayed by one cycle. Every other PE of the group receives 0.
- R2: A setup frame holds setupValid high for ADDR_W+2 cycles. The port line carries, in order: a request bit (1 means request), ADDR_W destination bits starting with the least significant bit, and an even-parity bit, which is the XOR of the address bits. The connection shows on `connected` from the clock edge that samples the parity bit.
- R3: Several good requests may name the same free output. The lowest-numbered source wins, and each loser gets `reject`. A request to an output that is already busy, or to a number of NUM_PORTS or more, also gets `reject`. A reject holds until the first cycle of the next setup frame or until a release.
- R4: A request whose parity bit does not match its address creates no connection and no reject. It sets the sticky `parityErr` bit of its source port.
- R5: While dataValid is high, a bit on a connected source reaches the destination port one cycle later. The forward output is 0 when dataValid is low or when the output is not connected.
- R6: While dataValid is high, a reply bit on a destination port reaches its connected source one cycle later. The reply output is 0 when dataValid is low or when the source is not connected.
- R7: A data word is DATA_W bits, least significant bit first, followed by one even-parity bit. On a mismatch, the receiving port's sticky `parityErr` is set: the destination port for forward data, and the source port for reply data.
- R8: releaseAll clears every connection, every reject and every parity error at the next edge. It takes priority over grants and error sets in the same cycle.
- R9: A request from a source that is already connected has no effect. Its circuit, its flags and the outputs stay unchanged.
- R10: After reset there are no connections, and all flags and received bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| peSel | input | $clog2(PES_PER_PORT) | Broadcast index of the PE in each group that uses the router |
| setupValid | input | 1 | Frames the setup phase for all ports |
| dataValid | input | 1 | Frames the data phase for all ports |
| releaseAll | input | 1 | Broadcast strobe that tears down every circuit |
| peTx | input | NUM_PORTS*PES_PER_PORT | Outgoing serial bit of each PE |
| peRplTx | input | NUM_PORTS*PES_PER_PORT | Reply serial bit of each PE acting as destination |
| peRx | output | NUM_PORTS*PES_PER_PORT | Forward serial bit delivered to each PE |
| peRplRx | output | NUM_PORTS*PES_PER_PORT | Reply serial bit delivered to each PE acting as source |
| connected | output | NUM_PORTS | Source port holds a circuit |
| reject | output | NUM_PORTS | Last valid request of the source was refused |
| parityErr | output | NUM_PORTS | Sticky parity error on the port |

## Verification
The bench builds the block with NUM_PORTS=4, PES_PER_PORT=4 and DATA_W=4. This gives a 2-bit address, 4-cycle setup frames and 5-cycle data words. With only four outputs, contention for one output, requests to busy outputs, and an ignored request from an already connected source all appear in a few frames. The PE index changes from frame to frame, so each group's select and deliver paths are covered for all four PEs. A behavioural model in the bench is compared with every output on every clock.

// File: rtl/serial_router_pkg.sv
package serial_router_pkg;
  typedef struct packed {
    logic reqBit;    // first bit of a setup frame
    logic addrBit;   // destination address bit on the line
    logic addrEnd;   // address parity bit on the line, arbitrate now
    logic dataBit;   // registered data bit present in pipe
    logic dataEnd;   // registered parity bit present in pipe
    logic dataIdle;  // no data word in flight
    logic clearAll;  // broadcast release
  } ctrl_strobe_t;
endpackage

// File: rtl/srt_ctrl.sv
module srt_ctrl
  import serial_router_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         setupValid,
  input  logic         dataValid,
  input  logic         releaseAll,
  output ctrl_strobe_t strobe
);
  localparam int SW = $clog2(ADDR_W + 2);
  localparam int DWW = $clog2(DATA_W + 1);
  localparam logic [SW-1:0] S_LAST = SW'(ADDR_W + 1);
  localparam logic [DWW-1:0] D_LAST = DWW'(DATA_W);

  logic [SW-1:0]  setupIdx;
  logic [DWW-1:0] dataIdx;
  logic           dataValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setupIdx   <= '0;
      dataIdx    <= '0;
      dataValidQ <= 1'b0;
    end else begin
      dataValidQ <= dataValid;
      if (!setupValid)              setupIdx <= '0;
      else if (setupIdx == S_LAST)  setupIdx <= '0;
      else                          setupIdx <= setupIdx + 1'b1;
      if (!dataValidQ)              dataIdx <= '0;
      else if (dataIdx == D_LAST)   dataIdx <= '0;
      else                          dataIdx <= dataIdx + 1'b1;
    end
  end

  always_comb begin
    strobe.reqBit   = setupValid && (setupIdx == '0);
    strobe.addrBit  = setupValid && (setupIdx != '0) && (setupIdx != S_LAST);
    strobe.addrEnd  = setupValid && (setupIdx == S_LAST);
    strobe.dataBit  = dataValidQ && (dataIdx != D_LAST);
    strobe.dataEnd  = dataValidQ && (dataIdx == D_LAST);
    strobe.dataIdle = !dataValidQ;
    strobe.clearAll = releaseAll;
  end

  // R2: parity slot of a setup frame follows a setup cycle
  p_addr_end_framed_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.addrEnd |-> $past(setupValid));
  // R7: word parity slot always follows a data bit slot
  p_data_end_after_bit_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dataEnd |-> $past(strobe.dataBit));
endmodule

// File: rtl/srt_datapath.sv
module srt_datapath
  import serial_router_pkg::*;
#(
  parameter int NUM_PORTS = 64,
  parameter int ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobe_t         strobe,
  input  logic                 dataValid,
  input  logic [NUM_PORTS-1:0] portTx,
  input  logic [NUM_PORTS-1:0] portRplTx,
  output logic [NUM_PORTS-1:0] fwdQ,
  output logic [NUM_PORTS-1:0] rplQ,
  output logic [NUM_PORTS-1:0] srcConn,
  output logic [NUM_PORTS-1:0] reject,
  output logic [NUM_PORTS-1:0] parityErr
);
  logic [NUM_PORTS-1:0] reqQ, addrPar, outBusy;
  logic [ADDR_W-1:0]    addrQ [NUM_PORTS];
  logic [ADDR_W-1:0]    srcOf [NUM_PORTS];
  logic [ADDR_W-1:0]    dstOf [NUM_PORTS];
  logic [NUM_PORTS-1:0] gnt   [NUM_PORTS];   // per output, one-hot source
  logic [ADDR_W-1:0]    newSrc[NUM_PORTS];
  logic [ADDR_W-1:0]    newDst[NUM_PORTS];
  logic [NUM_PORTS-1:0] reqOk, badAddr, srcGranted;
  logic [NUM_PORTS-1:0] accF, accR, fwdBad, rplBad;

  // setup shift-in, LSB first
  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_PORTS; s++) begin
      if (strobe.reqBit) begin
        reqQ[s]    <= portTx[s];
        addrPar[s] <= 1'b0;
        addrQ[s]   <= '0;
      end else if (strobe.addrBit) begin
        addrQ[s]   <= (addrQ[s] >> 1) | (ADDR_W'(portTx[s]) << (ADDR_W - 1));
        addrPar[s] <= addrPar[s] ^ portTx[s];
      end
    end
  end

  // arbitration: lowest source wins each free output
  always_comb begin
    logic [NUM_PORTS-1:0] cand;
    reqOk   = reqQ & ~srcConn & ~(addrPar ^ portTx);
    badAddr = {NUM_PORTS{strobe.addrEnd}} & reqQ & ~srcConn & (addrPar ^ portTx);
    srcGranted = '0;
    for (int d = 0; d < NUM_PORTS; d++) begin
      for (int s = 0; s < NUM_PORTS; s++)
        cand[s] = reqOk[s] && (addrQ[s] == ADDR_W'(d)) && !outBusy[d];
      gnt[d] = cand & (~cand + 1'b1);
      srcGranted = srcGranted | gnt[d];
    end
    for (int d = 0; d < NUM_PORTS; d++) begin
      newSrc[d] = '0;
      newDst[d] = '0;
    end
    for (int d = 0; d < NUM_PORTS; d++)
      for (int s = 0; s < NUM_PORTS; s++)
        if (gnt[d][s]) begin
          newSrc[d] = ADDR_W'(s);
          newDst[s] = ADDR_W'(d);
        end
  end

  assign fwdBad = {NUM_PORTS{strobe.dataEnd}} & outBusy & (accF ^ fwdQ);
  assign rplBad = {NUM_PORTS{strobe.dataEnd}} & srcConn & (accR ^ rplQ);

  // circuit state and flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outBusy <= '0; srcConn <= '0; reject <= '0; parityErr <= '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        srcOf[p] <= '0; dstOf[p] <= '0;
      end
    end else if (strobe.clearAll) begin
      outBusy <= '0; srcConn <= '0; reject <= '0; parityErr <= '0;
    end else begin
      parityErr <= parityErr | badAddr | fwdBad | rplBad;
      if (strobe.reqBit) reject <= '0;
      else if (strobe.addrEnd) reject <= reqOk & ~srcGranted;
      if (strobe.addrEnd) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (|gnt[p]) begin
            outBusy[p] <= 1'b1;
            srcOf[p]   <= newSrc[p];
          end
          if (srcGranted[p]) begin
            srcConn[p] <= 1'b1;
            dstOf[p]   <= newDst[p];
          end
        end
      end
    end
  end

  // crossbar both ways with one register stage, plus parity accumulators
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdQ <= '0; rplQ <= '0; accF <= '0; accR <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        fwdQ[p] <= dataValid && outBusy[p] && portTx[srcOf[p]];
        rplQ[p] <= dataValid && srcConn[p] && portRplTx[dstOf[p]];
      end
      if (strobe.dataIdle || strobe.dataEnd) begin
        accF <= '0; accR <= '0;
      end else if (strobe.dataBit) begin
        accF <= accF ^ fwdQ;
        accR <= accR ^ rplQ;
      end
    end
  end

  // R3: a busy output has exactly one source, so the counts stay equal
  p_pair_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(outBusy) == $countones(srcConn));
  // R3: a refused source never holds a circuit
  p_reject_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reject & srcConn) == '0);
  // R5 / R6: lines idle outside the data phase
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |=> (fwdQ == '0) && (rplQ == '0));
  // R8: release empties the router
  p_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (srcConn == '0) && (reject == '0) && (parityErr == '0));
  // R7: error bits only fall on release
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clearAll |=> ((parityErr & $past(parityErr)) == $past(parityErr)));
endmodule

// File: rtl/srt_concentrator.sv
module srt_concentrator #(
  parameter int NUM_PORTS    = 64,
  parameter int PES_PER_PORT = 16,
  localparam int SEL_W       = $clog2(PES_PER_PORT),
  localparam int PE_TOTAL    = NUM_PORTS * PES_PER_PORT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SEL_W-1:0]     peSel,
  input  logic [PE_TOTAL-1:0]  peTx,
  input  logic [PE_TOTAL-1:0]  peRplTx,
  input  logic [NUM_PORTS-1:0] fwdQ,
  input  logic [NUM_PORTS-1:0] rplQ,
  output logic [NUM_PORTS-1:0] portTx,
  output logic [NUM_PORTS-1:0] portRplTx,
  output logic [PE_TOTAL-1:0]  peRx,
  output logic [PE_TOTAL-1:0]  peRplRx
);
  logic [SEL_W-1:0] selQ;

  always_ff @(posedge clk) begin
    if (!rstN) selQ <= '0;
    else       selQ <= peSel;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PES_PER_PORT-1:0] txGrp, rplGrp;
    assign txGrp        = peTx[p*PES_PER_PORT +: PES_PER_PORT];
    assign rplGrp       = peRplTx[p*PES_PER_PORT +: PES_PER_PORT];
    assign portTx[p]    = txGrp[peSel];
    assign portRplTx[p] = rplGrp[peSel];
    for (genvar k = 0; k < PES_PER_PORT; k++) begin : g_pe
      assign peRx[p*PES_PER_PORT+k]    = fwdQ[p] && (selQ == SEL_W'(k));
      assign peRplRx[p*PES_PER_PORT+k] = rplQ[p] && (selQ == SEL_W'(k));
    end
  end

  // R1: at most one PE of a group sees received data
  p_single_pe_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(peRx) <= $countones(fwdQ));
endmodule

// File: rtl/serial_router.sv
module serial_router
  import serial_router_pkg::*;
#(
  parameter int NUM_PORTS    = 64,
  parameter int PES_PER_PORT = 16,
  parameter int DATA_W       = 8,
  localparam int ADDR_W      = $clog2(NUM_PORTS),
  localparam int SEL_W       = $clog2(PES_PER_PORT),
  localparam int PE_TOTAL    = NUM_PORTS * PES_PER_PORT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SEL_W-1:0]     peSel,
  input  logic                 setupValid,
  input  logic                 dataValid,
  input  logic                 releaseAll,
  input  logic [PE_TOTAL-1:0]  peTx,
  input  logic [PE_TOTAL-1:0]  peRplTx,
  output logic [PE_TOTAL-1:0]  peRx,
  output logic [PE_TOTAL-1:0]  peRplRx,
  output logic [NUM_PORTS-1:0] connected,
  output logic [NUM_PORTS-1:0] reject,
  output logic [NUM_PORTS-1:0] parityErr
);
  ctrl_strobe_t         strobe;
  logic [NUM_PORTS-1:0] portTx, portRplTx, fwdQ, rplQ;

  srt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .setupValid(setupValid), .dataValid(dataValid),
    .releaseAll(releaseAll), .strobe(strobe));

  srt_concentrator #(.NUM_PORTS(NUM_PORTS), .PES_PER_PORT(PES_PER_PORT)) u_conc (
    .clk(clk), .rstN(rstN), .peSel(peSel), .peTx(peTx), .peRplTx(peRplTx),
    .fwdQ(fwdQ), .rplQ(rplQ), .portTx(portTx), .portRplTx(portRplTx),
    .peRx(peRx), .peRplRx(peRplRx));

  srt_datapath #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataValid(dataValid),
    .portTx(portTx), .portRplTx(portRplTx), .fwdQ(fwdQ), .rplQ(rplQ),
    .srcConn(connected), .reject(reject), .parityErr(parityErr));
endmodule

// File: tb/serial_router_bench.sv
module serial_router_bench;
  localparam int N = 4, P = 4, DW = 4, AW = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] peSel = '0;
  logic setupValid = 0, dataValid = 0, releaseAll = 0;
  logic [N*P-1:0] peTx = '0, peRplTx = '0, peRx, peRplRx;
  logic [N-1:0] connected, reject, parityErr;

  serial_router #(.NUM_PORTS(N), .PES_PER_PORT(P), .DATA_W(DW)) u_serial_router (
    .clk(clk), .rstN(rstN), .peSel(peSel), .setupValid(setupValid),
    .dataValid(dataValid), .releaseAll(releaseAll), .peTx(peTx), .peRplTx(peRplTx),
    .peRx(peRx), .peRplRx(peRplRx), .connected(connected), .reject(reject),
    .parityErr(parityErr));

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mSrc[N], mDst[N], mAddr[N];
  bit mRej[N], mErr[N], mFwd[N], mRpl[N], mReq[N], mPar[N], mAccF[N], mAccR[N];
  bit mV1;
  int mSelQ, mSIdx, mDIdx;

  task automatic modelStep();
    bit nf[N], nr[N], b[N], ok[N];
    if (mV1) begin
      if (mDIdx == DW) begin
        for (int p = 0; p < N; p++) begin
          if (mSrc[p] >= 0 && (mAccF[p] ^ mFwd[p])) mErr[p] = 1;
          if (mDst[p] >= 0 && (mAccR[p] ^ mRpl[p])) mErr[p] = 1;
          mAccF[p] = 0; mAccR[p] = 0;
        end
        mDIdx = 0;
      end else begin
        for (int p = 0; p < N; p++) begin
          mAccF[p] ^= mFwd[p]; mAccR[p] ^= mRpl[p];
        end
        mDIdx++;
      end
    end else begin
      mDIdx = 0;
      for (int p = 0; p < N; p++) begin mAccF[p] = 0; mAccR[p] = 0; end
    end
    for (int p = 0; p < N; p++) begin
      nf[p] = dataValid && mSrc[p] >= 0 && peTx[mSrc[p]*P + int'(peSel)];
      nr[p] = dataValid && mDst[p] >= 0 && peRplTx[mDst[p]*P + int'(peSel)];
    end
    mFwd = nf; mRpl = nr; mV1 = dataValid; mSelQ = int'(peSel);
    if (setupValid) begin
      for (int p = 0; p < N; p++) b[p] = peTx[p*P + int'(peSel)];
      if (mSIdx == 0) begin
        for (int p = 0; p < N; p++) begin
          mReq[p] = b[p]; mAddr[p] = 0; mPar[p] = 0; mRej[p] = 0;
        end
      end else if (mSIdx <= AW) begin
        for (int p = 0; p < N; p++) begin
          mAddr[p] += int'(b[p]) << (mSIdx - 1); mPar[p] ^= b[p];
        end
      end else begin
        for (int s = 0; s < N; s++) begin
          ok[s] = mReq[s] && mDst[s] < 0;
          if (ok[s] && (mPar[s] ^ b[s])) begin mErr[s] = 1; ok[s] = 0; end
        end
        for (int s = 0; s < N; s++)
          if (ok[s]) begin
            if (mAddr[s] < N && mSrc[mAddr[s]] < 0) begin
              mSrc[mAddr[s]] = s; mDst[s] = mAddr[s];
            end else mRej[s] = 1;
          end
      end
      mSIdx = (mSIdx == AW + 1) ? 0 : mSIdx + 1;
    end else mSIdx = 0;
    if (releaseAll)
      for (int p = 0; p < N; p++) begin
        mSrc[p] = -1; mDst[p] = -1; mRej[p] = 0; mErr[p] = 0;
      end
  endtask

  task automatic modelReset();
    for (int p = 0; p < N; p++) begin
      mSrc[p] = -1; mDst[p] = -1; mRej[p] = 0; mErr[p] = 0; mFwd[p] = 0;
      mRpl[p] = 0; mAccF[p] = 0; mAccR[p] = 0; mReq[p] = 0; mAddr[p] = 0; mPar[p] = 0;
    end
    mV1 = 0; mSelQ = 0; mSIdx = 0; mDIdx = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else modelStep();
    #1;
    if (rstN && !done) begin
      logic [N-1:0] eConn, eRej, eErr;
      logic [N*P-1:0] eRx, eRpl;
      for (int p = 0; p < N; p++) begin
        eConn[p] = mDst[p] >= 0; eRej[p] = mRej[p]; eErr[p] = mErr[p];
        for (int k = 0; k < P; k++) begin
          eRx[p*P+k]  = (k == mSelQ) && mFwd[p];
          eRpl[p*P+k] = (k == mSelQ) && mRpl[p];
        end
      end
      chk("R2 connected", 32'(connected), 32'(eConn));
      chk("R3 reject", 32'(reject), 32'(eRej));
      chk("R7 R4 parityErr", 32'(parityErr), 32'(eErr));
      chk("R5 R1 peRx", 32'(peRx), 32'(eRx));
      chk("R6 R1 peRplRx", 32'(peRplRx), 32'(eRpl));
    end
  end

  // ---------------- stimulus ----------------
  task automatic setupFrame(input int sel, input logic [N-1:0] req, input int dst[N],
                            input logic [N-1:0] badPar);
    for (int c = 0; c < AW + 2; c++) begin
      @(negedge clk);
      setupValid = 1; peSel = 2'(sel); peTx = (N*P)'($urandom);
      for (int p = 0; p < N; p++) begin
        bit v;
        if (c == 0) v = req[p];
        else if (c <= AW) v = dst[p][c-1];
        else v = dst[p][0] ^ dst[p][1] ^ badPar[p];
        peTx[p*P + sel] = v;
      end
    end
    @(negedge clk);
    setupValid = 0; peTx = '0;
  endtask

  task automatic dataFrame(input int sel, input int fw[N], input int rp[N],
                           input logic [N-1:0] badF, input logic [N-1:0] badR);
    for (int c = 0; c <= DW; c++) begin
      @(negedge clk);
      dataValid = 1; peSel = 2'(sel);
      peTx = (N*P)'($urandom); peRplTx = (N*P)'($urandom);
      for (int p = 0; p < N; p++) begin
        bit f, r;
        if (c < DW) begin f = fw[p][c]; r = rp[p][c]; end
        else begin f = (^fw[p][DW-1:0]) ^ badF[p]; r = (^rp[p][DW-1:0]) ^ badR[p]; end
        peTx[p*P + sel] = f; peRplTx[p*P + sel] = r;
      end
    end
    @(negedge clk);
    dataValid = 0; peTx = '0; peRplTx = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 connected after reset", 32'(connected), 0);
    chk("R10 flags after reset", 32'({reject, parityErr}), 0);
    chk("R10 rx after reset", 32'({peRx, peRplRx}), 0);
    rstN = 1;
    @(negedge clk);
    // src0,src1 -> 2 (contention), src2 -> 3 bad parity, src3 -> 1
    setupFrame(1, 4'b1111, '{2, 2, 3, 1}, 4'b0100);
    chk("R3 R2 connected after frame1", 32'(connected), 32'b1001);
    chk("R3 reject loser", 32'(reject), 32'b0010);
    chk("R4 address parity error", 32'(parityErr), 32'b0100);
    // forward from src3 bad, reply from port1 bad
    dataFrame(2, '{10, 0, 0, 5}, '{0, 6, 3, 0}, 4'b1000, 4'b0010);
    chk("R7 data parity errors", 32'(parityErr), 32'b1110);
    // src0 connected asks again (ignored), src1 retry to 0, src2 to busy 1
    setupFrame(0, 4'b0111, '{3, 0, 1, 0}, 4'b0000);
    chk("R9 R3 connected after frame2", 32'(connected), 32'b1011);
    chk("R3 reject busy output", 32'(reject), 32'b0100);
    dataFrame(3, '{3, 9, 0, 12}, '{6, 0, 5, 11}, 4'b0000, 4'b0000);
    chk("R7 good words keep errors", 32'(parityErr), 32'b1110);
    @(negedge clk); releaseAll = 1;
    @(negedge clk); releaseAll = 0;
    chk("R8 release clears", 32'({connected, reject, parityErr}), 0);
    // three sources to output 0: src0 wins
    setupFrame(3, 4'b1101, '{0, 0, 0, 0}, 4'b0000);
    chk("R3 lowest wins", 32'(connected), 32'b0001);
    chk("R3 two losers", 32'(reject), 32'b1100);
    dataFrame(1, '{7, 0, 0, 0}, '{13, 0, 0, 0}, 4'b0000, 4'b0000);
    setupFrame(1, 4'b0000, '{0, 0, 0, 0}, 4'b0000);
    chk("R3 reject cleared by next frame", 32'(reject), 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule